// File: doc/BRIEF.md
# Debug Command Gating Controller

This block sits behind the serial front end of a single-wire background debug unit. Each decoded request arrives as a class code and an instruction byte. The block decides whether the request may run, taking into account the power state of the CPU. It records the instruction of every accepted request and tracks whether a command is in progress. It also holds the acknowledge-handshake enable.

The block owns the debug clock enable. It drops the enable while every bus master is stopped. When a master wakes again, it raises the enable and issues a one-cycle soft reset that wipes the command state. It also refuses CPU low-power requests while debug mode is active. During system reset it samples the debug pin once, and that level selects normal or special operating mode.

Requests use a valid/ready handshake. A request transfers in a cycle where `cmd_valid` and `cmd_ready` are both high. The sender must hold `cmd_valid`, `cmd_class` and `cmd_code` steady until that cycle. `cmd_ready` stays low under three conditions:
- a command is in progress;
- the debug clock is off;
- a soft reset is underway.

Every transfer is answered one cycle later by exactly one pulse, either `cmd_acc` or `cmd_rej`. A rejected request is consumed and dropped.

Top module: `dbg_cmd_gate`

## Requirements
- R1: While `cpu_wait` or `cpu_stop` is high, any request of class 2'b01 (hardware background entry), 2'b10 (firmware-executed) or 2'b11 (acknowledge control) is rejected. It leaves `cmd_instr`, `cmd_busy` and `ack_en` unchanged.
- R2: While `cpu_wait` or `cpu_stop` is high, a class 2'b00 request (hardware memory read/write) is accepted.
- R3: With the CPU in neither wait nor stop, every class is accepted. Each transfer gives exactly one one-cycle pulse on `cmd_acc` or `cmd_rej`, in the cycle after the transfer.
- R4: `cpu_lp_grant` is high exactly when `cpu_lp_req` is high and `dbg_active` is low.
- R5: An accepted request of class 2'b00, 2'b01 or 2'b10 loads `cmd_code` into `cmd_instr` and raises `cmd_busy`. While `cmd_busy` is high, `cmd_ready` is low. A `cmd_done` pulse clears `cmd_busy`.
- R6: One cycle after `all_stopped` is seen high, `dbg_clk_en` is low, and it stays low while `all_stopped` remains high. `cmd_ready` is low while `dbg_clk_en` is low.
- R7: In the cycle after `all_stopped` falls while `dbg_clk_en` is low, the following hold:
  - `dbg_clk_en` is high;
  - `soft_rst` is high for exactly that one cycle;
  - `cmd_instr` is 0, `cmd_busy` is low and `ack_en` is low;
  - `cmd_ready` is low.

  `cmd_ready` returns high one cycle later.
- R8: An accepted class 2'b11 request sets `ack_en` when `cmd_code[0]` is 1 and clears it when `cmd_code[0]` is 0. It does not change `cmd_busy` or `cmd_instr`. `ack_en` is 0 after system reset.
- R9: `mode_special` takes the level of `dbg_pin` at the last clock edge before `rst_n` rises. It then stays constant until the next reset, whatever `dbg_pin` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| dbg_pin | input | 1 | Debug pin level, used as the mode strap during reset |
| cpu_wait | input | 1 | CPU is in wait mode |
| cpu_stop | input | 1 | CPU is in stop mode |
| all_stopped | input | 1 | Every bus master is in stop mode |
| dbg_active | input | 1 | Debug-active mode asserted |
| cpu_lp_req | input | 1 | CPU requests entry into a low-power mode |
| cpu_lp_grant | output | 1 | Low-power entry permitted |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Block can take a request |
| cmd_class | input | 2 | Request class: 00 rd/wr, 01 background, 10 firmware, 11 ack control |
| cmd_code | input | 8 | Instruction byte of the request |
| cmd_done | input | 1 | Datapath finished the command in progress |
| cmd_acc | output | 1 | One-cycle accept pulse |
| cmd_rej | output | 1 | One-cycle reject pulse |
| cmd_instr | output | 8 | Instruction register |
| cmd_busy | output | 1 | Command in progress |
| ack_en | output | 1 | Acknowledge handshake enabled |
| dbg_clk_en | output | 1 | Debug clock enable |
| soft_rst | output | 1 | One-cycle soft reset after clock restart |
| mode_special | output | 1 | Latched mode select, 1 = special |

## Verification
The hardest state to reach is a clock restart while the block holds live state. At that moment the acknowledge enable must be set, a command must be in progress, and the instruction register must be loaded, so that the soft reset has something to clear.

The stimulus builds this state in order:
1. An acknowledge-enable request sets `ack_en`.
2. A read/write request is accepted, and `cmd_done` is withheld so the command stays in progress.
3. `all_stopped` is raised until the clock enable drops, then lowered.

The bench then checks the cleared state and `cmd_ready` on the exact cycle of the soft reset, and again on the cycle after it.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  typedef enum logic [1:0] {
    CLS_HWRW   = 2'b00,
    CLS_BGND   = 2'b01,
    CLS_FW     = 2'b10,
    CLS_ACKCTL = 2'b11
  } cmd_cls_e;
endpackage

// File: rtl/dbg_mode_latch.sv
module dbg_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic mode_special
);
  logic mode_q;

  // Track the strap while reset is held; freeze once released.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= pin;
  end

  assign mode_special = mode_q;

  AST_MODE_STABLE: assert property (@(posedge clk)
    rst_n && $past(rst_n) |-> $stable(mode_q)); // R9
endmodule

// File: rtl/dbg_clk_ctrl.sv
module dbg_clk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic all_stopped,
  output logic clk_en,
  output logic soft_rst,
  output logic restart
);
  logic en_q, srst_q;

  assign restart = !en_q && !all_stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      srst_q <= 1'b0;
    end else begin
      en_q   <= !all_stopped;
      srst_q <= restart;
    end
  end

  assign clk_en   = en_q;
  assign soft_rst = srst_q;

  AST_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    all_stopped |=> !clk_en); // R6
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst); // R7
endmodule

// File: rtl/dbg_cmd_arb.sv
module dbg_cmd_arb
  import dbg_gate_pkg::*;
#(
  parameter int INSTR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               hold,
  input  logic               low_pwr,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_class,
  input  logic [INSTR_W-1:0] cmd_code,
  input  logic               cmd_done,
  output logic               acc,
  output logic               rej,
  output logic [INSTR_W-1:0] instr,
  output logic               busy,
  output logic               ack_en
);
  cmd_cls_e cls;
  logic fire, allowed, take;
  logic acc_q, rej_q, busy_q, ack_q;
  logic [INSTR_W-1:0] instr_q;

  assign cls       = cmd_cls_e'(cmd_class);
  assign cmd_ready = !hold && !busy_q;
  assign fire      = cmd_valid && cmd_ready;
  assign allowed   = (cls == CLS_HWRW) || !low_pwr;
  assign take      = fire && allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
      busy_q  <= 1'b0;
      ack_q   <= 1'b0;
      instr_q <= '0;
    end else if (flush) begin
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
      busy_q  <= 1'b0;
      ack_q   <= 1'b0;
      instr_q <= '0;
    end else begin
      acc_q <= take;
      rej_q <= fire && !allowed;
      if (take && cls == CLS_ACKCTL) begin
        ack_q <= cmd_code[0];
      end else if (take) begin
        busy_q  <= 1'b1;
        instr_q <= cmd_code;
      end else if (cmd_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign acc    = acc_q;
  assign rej    = rej_q;
  assign busy   = busy_q;
  assign instr  = instr_q;
  assign ack_en = ack_q;

  AST_LP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && low_pwr && cls != CLS_HWRW && !flush |=> rej && !acc); // R1
  AST_LP_RDWR_OK: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cls == CLS_HWRW && !flush |=> acc); // R2
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && rej)); // R3
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R5
endmodule

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
  import dbg_gate_pkg::*;
#(
  parameter int INSTR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbg_pin,
  input  logic               cpu_wait,
  input  logic               cpu_stop,
  input  logic               all_stopped,
  input  logic               dbg_active,
  input  logic               cpu_lp_req,
  output logic               cpu_lp_grant,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_class,
  input  logic [INSTR_W-1:0] cmd_code,
  input  logic               cmd_done,
  output logic               cmd_acc,
  output logic               cmd_rej,
  output logic [INSTR_W-1:0] cmd_instr,
  output logic               cmd_busy,
  output logic               ack_en,
  output logic               dbg_clk_en,
  output logic               soft_rst,
  output logic               mode_special
);
  logic restart;

  assign cpu_lp_grant = cpu_lp_req && !dbg_active;

  dbg_mode_latch u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin          (dbg_pin),
    .mode_special (mode_special)
  );

  dbg_clk_ctrl u_clk (
    .clk         (clk),
    .rst_n       (rst_n),
    .all_stopped (all_stopped),
    .clk_en      (dbg_clk_en),
    .soft_rst    (soft_rst),
    .restart     (restart)
  );

  dbg_cmd_arb #(.INSTR_W(INSTR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (restart),
    .hold      (!dbg_clk_en || soft_rst),
    .low_pwr   (cpu_wait || cpu_stop),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_class (cmd_class),
    .cmd_code  (cmd_code),
    .cmd_done  (cmd_done),
    .acc       (cmd_acc),
    .rej       (cmd_rej),
    .instr     (cmd_instr),
    .busy      (cmd_busy),
    .ack_en    (ack_en)
  );

  AST_NO_LP_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |-> !cpu_lp_grant); // R4
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !ack_en && !cmd_busy && cmd_instr == '0 && !cmd_ready); // R7
endmodule

// File: tb/dbg_cmd_gate_tb.sv
module dbg_cmd_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_pin = 1'b1, cpu_wait = 1'b0, cpu_stop = 1'b0, all_stopped = 1'b0;
  logic dbg_active = 1'b0, cpu_lp_req = 1'b0, cmd_valid = 1'b0, cmd_done = 1'b0;
  logic [1:0] cmd_class = 2'b00;
  logic [7:0] cmd_code = 8'h00;
  logic cpu_lp_grant, cmd_ready, cmd_acc, cmd_rej, cmd_busy, ack_en;
  logic dbg_clk_en, soft_rst, mode_special;
  logic [7:0] cmd_instr;

  int checks = 0;
  int errors = 0;
  bit expq[$];
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  dbg_cmd_gate u_dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pop one expected outcome per response pulse.
  always @(negedge clk) begin
    if (rst_n && (cmd_acc || cmd_rej)) begin
      if (expq.size() == 0) begin
        check("R3 unexpected pulse", 1, 0);
      end else begin
        bit e;
        e = expq.pop_front();
        check("R3 one pulse", int'(cmd_acc) + int'(cmd_rej), 1);
        check("R1/R2/R3 accept", int'(cmd_acc), int'(e));
      end
    end
  end

  task automatic send(logic [1:0] cls, logic [7:0] code, bit exp_acc);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_class = cls; cmd_code = code;
    expq.push_back(exp_acc);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_cmd();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    dbg_pin = 1'b0;
    check("R9 mode latched", mode_special, 1);
    check("R6 clk on after reset", dbg_clk_en, 1);
    check("R8 ack off after reset", ack_en, 0);
    check("R5 ready after reset", cmd_ready, 1);

    // R3: full power, every class accepted
    send(2'b00, 8'h11, 1'b1);
    check("R5 instr load", cmd_instr, 8'h11);
    check("R5 busy", cmd_busy, 1);
    check("R5 ready low while busy", cmd_ready, 0);
    finish_cmd();
    check("R5 done clears busy", cmd_busy, 0);
    send(2'b01, 8'h22, 1'b1); finish_cmd();
    send(2'b10, 8'h33, 1'b1); finish_cmd();
    check("R3 firmware instr", cmd_instr, 8'h33);

    // R8 ack control
    send(2'b11, 8'h01, 1'b1);
    check("R8 ack set", ack_en, 1);
    check("R8 instr untouched", cmd_instr, 8'h33);
    send(2'b11, 8'h00, 1'b1);
    check("R8 ack clear", ack_en, 0);

    // R1/R2 low power
    cpu_wait = 1'b1;
    send(2'b01, 8'h44, 1'b0);
    send(2'b10, 8'h55, 1'b0);
    send(2'b11, 8'h01, 1'b0);
    check("R1 instr kept", cmd_instr, 8'h33);
    check("R1 ack kept", ack_en, 0);
    check("R1 not busy", cmd_busy, 0);
    send(2'b00, 8'h66, 1'b1); finish_cmd();
    check("R2 rdwr in wait", cmd_instr, 8'h66);
    cpu_wait = 1'b0; cpu_stop = 1'b1;
    send(2'b10, 8'h77, 1'b0);
    send(2'b00, 8'h78, 1'b1); finish_cmd();
    cpu_stop = 1'b0;

    // R4
    @(negedge clk);
    cpu_lp_req = 1'b1; dbg_active = 1'b1;
    #1 check("R4 blocked in debug", cpu_lp_grant, 0);
    dbg_active = 1'b0;
    #1 check("R4 granted", cpu_lp_grant, 1);
    cpu_lp_req = 1'b0;

    // R6/R7 restart with live state
    send(2'b11, 8'h01, 1'b1);
    send(2'b00, 8'h9A, 1'b1);
    check("R7 pre busy", cmd_busy, 1);
    all_stopped = 1'b1;
    @(negedge clk);
    check("R6 clk off", dbg_clk_en, 0);
    check("R6 ready off", cmd_ready, 0);
    @(negedge clk);
    check("R6 clk stays off", dbg_clk_en, 0);
    all_stopped = 1'b0;
    @(negedge clk);
    check("R7 clk back", dbg_clk_en, 1);
    check("R7 soft rst", soft_rst, 1);
    check("R7 ack cleared", ack_en, 0);
    check("R7 busy cleared", cmd_busy, 0);
    check("R7 instr cleared", cmd_instr, 0);
    check("R7 ready low in srst", cmd_ready, 0);
    @(negedge clk);
    check("R7 srst one cycle", soft_rst, 0);
    check("R7 ready after", cmd_ready, 1);
    send(2'b10, 8'h5C, 1'b1); finish_cmd();

    dbg_pin = 1'b1;
    @(negedge clk);
    check("R9 mode stable", mode_special, 1);
    repeat (3) @(negedge clk);
    check("R3 all responses seen", expq.size(), 0);
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        check("watchdog", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule